// File: doc/BRIEF.md
# Byte-Stepped I2C Master Controller

This block is an I2C bus master that software drives through a small register window, one bus event at a time. Software asks for a START, a repeated START or a STOP by setting control bits. It loads address and data bytes into a data register and chooses whether received bytes are acknowledged. When an event finishes, the controller raises a flag bit, posts a one-byte status code that names the event and its outcome, and keeps SCL low. The bus does not move again until software writes the flag back to zero. A STOP is the one exception: it leaves the flag clear and returns the engine to rest.

The bus engine is a state machine with the states IDLE, START, RSTART, ADDR, WRITE, READ, HOLD and STOP. IDLE goes to START when the enable and start bits are set and the flag is clear. START, RSTART, ADDR, WRITE and READ each end in HOLD, and that transition sets the flag. HOLD waits until the flag is zero. It then picks the next step in priority order: STOP if the stop bit is set, then RSTART if the start bit is set, then ADDR if the last event was a START or repeated START, then READ if the address asked for a read, and WRITE otherwise. STOP returns to IDLE. A write to the soft-reset offset sends every state straight to IDLE. The SCL rate comes from two divider fields in the rate register. A bit cell lasts ten divider ticks, and SCL is high for five of them.

Top module: `i2cm_ctrl`

## Requirements
- R1: After reset the status register (offset 0x0C read) is 0xF8, the control register (offset 0x08) reads 0x00, irq is low, and neither bus line is pulled.
- R2: Writing the control register with start (bit 5) and enable (bit 6) set drives a START on the bus. The controller then sets the flag (bit 3), posts status 0x08 and clears the start bit. With enable clear, the start bit causes no bus activity.
- R3: While the flag is set, SCL is held low and no new event begins. Only a control write with bit 3 at zero clears the flag. Writing a one to bit 3 leaves it unchanged.
- R4: After the flag is cleared following a START, the byte held in the data register (offset 0x04) is sent MSB first, with SDA changing only while SCL is low. Status becomes 0x18 (bit 0 clear, acknowledged), 0x20 (bit 0 clear, not acknowledged), 0x40 (bit 0 set, acknowledged) or 0x48 (bit 0 set, not acknowledged).
- R5: In a write transfer, each byte loaded into the data register is sent after the flag is cleared. Status becomes 0x28 if the byte is acknowledged and 0x30 if it is not.
- R6: In a read transfer, each flag clear receives one byte into the data register. If ack (bit 2) was set, the master drives an acknowledge and status becomes 0x50. If ack was clear, no acknowledge is driven and status becomes 0x58.
- R7: Setting start while the flag is set produces a repeated START once the flag is cleared, with status 0x10.
- R8: Setting stop (bit 4) with the flag clear drives a STOP condition. The stop bit then clears itself, status becomes 0xF8, the flag stays clear and both lines are released.
- R9: A write to offset 0x0C loads the rate register: M in bits 6:3 and N in bits 2:0. Each SCL high phase within a byte lasts 5·(M+1)·2^N clock cycles.
- R10: Any write to offset 0x1C returns the controller at once to the state of R1.
- R11: irq is high exactly when the flag and interrupt enable (bit 7) are both set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | Interrupt request |
| scl_pull | output | 1 | High pulls SCL low |
| sda_pull | output | 1 | High pulls SDA low |
| sda_in | input | 1 | Sensed SDA line level |

## Verification
A bad engine state shows up at the ports within one SCL bit cell. It appears as an extra or missing START or STOP seen by the bench's bus slave, as a shifted or corrupted byte, or as SCL released while the flag is still set. A wrong status or acknowledge choice appears in the status register as soon as the flag rises. The bench checks this on every event. It also checks, on every clock, that SCL stays low while it knows the flag is set. A divider fault shows up in the measured SCL high time on the first byte at each rate setting.

// File: rtl/i2cm_pkg.sv
package i2cm_pkg;
    typedef enum logic [2:0] {
        ENG_IDLE, ENG_START, ENG_RSTART, ENG_ADDR,
        ENG_WRITE, ENG_READ, ENG_HOLD, ENG_STOP
    } eng_state_t;

    localparam int BYTE_W = 8;

    localparam logic [7:0] ST_START   = 8'h08;
    localparam logic [7:0] ST_RSTART  = 8'h10;
    localparam logic [7:0] ST_AW_ACK  = 8'h18;
    localparam logic [7:0] ST_AW_NAK  = 8'h20;
    localparam logic [7:0] ST_DW_ACK  = 8'h28;
    localparam logic [7:0] ST_DW_NAK  = 8'h30;
    localparam logic [7:0] ST_AR_ACK  = 8'h40;
    localparam logic [7:0] ST_AR_NAK  = 8'h48;
    localparam logic [7:0] ST_DR_ACK  = 8'h50;
    localparam logic [7:0] ST_DR_NAK  = 8'h58;
    localparam logic [7:0] ST_IDLE    = 8'hF8;

    localparam int CB_ACK   = 2;
    localparam int CB_FLAG  = 3;
    localparam int CB_STOP  = 4;
    localparam int CB_START = 5;
    localparam int CB_EN    = 6;
    localparam int CB_IEN   = 7;

    localparam int OFS_DATA = 'h04;
    localparam int OFS_CTRL = 'h08;
    localparam int OFS_STAT = 'h0C;
    localparam int OFS_SRST = 'h1C;
endpackage

// File: rtl/i2cm_tick.sv
module i2cm_tick #(
    parameter int M_W = 4,
    parameter int N_W = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic [M_W-1:0] m_fld,
    input  logic [N_W-1:0] n_fld,
    output logic           tick
);
    localparam int CNT_W = M_W + (1 << N_W);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] limit;

    assign limit = ((CNT_W'(m_fld) + CNT_W'(1)) << n_fld) - CNT_W'(1);
    assign tick  = run && (cnt == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (!run || tick)   cnt <= '0;
        else                     cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/i2cm_fsm.sv
module i2cm_fsm
    import i2cm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              tick,
    input  logic              en,
    input  logic              start_req,
    input  logic              stop_req,
    input  logic              ack_en,
    input  logic              flag,
    input  logic [BYTE_W-1:0] tx_byte,
    input  logic              sda_in,
    output eng_state_t        state_o,
    output logic              run,
    output logic              scl_pull,
    output logic              sda_pull,
    output logic              ev_done,
    output logic [7:0]        ev_code,
    output logic [BYTE_W-1:0] rx_byte
);
    localparam logic [3:0] PH_START_LAST = 4'd4;
    localparam logic [3:0] PH_BIT_LAST   = 4'd9;
    localparam logic [3:0] PH_LONG_LAST  = 4'd14;
    localparam logic [3:0] PH_SAMPLE     = 4'd5;
    localparam logic [3:0] BIT_ACK       = 4'd8;

    eng_state_t        state;
    logic [3:0]        ph, bitn, last_ph;
    logic [BYTE_W-1:0] shreg;
    logic              rd_dir, got_ack, ack_q, after_start, is_byte;

    assign state_o = state;
    assign run     = (state != ENG_IDLE) && (state != ENG_HOLD);
    assign is_byte = (state == ENG_ADDR) || (state == ENG_WRITE) || (state == ENG_READ);
    assign rx_byte = shreg;

    always_comb begin
        unique case (state)
            ENG_START:             last_ph = PH_START_LAST;
            ENG_RSTART, ENG_STOP:  last_ph = PH_LONG_LAST;
            default:               last_ph = PH_BIT_LAST;
        endcase
    end

    assign ev_done = run && tick && (ph == last_ph) && (!is_byte || bitn == BIT_ACK);

    always_comb begin
        unique case (state)
            ENG_START:  ev_code = ST_START;
            ENG_RSTART: ev_code = ST_RSTART;
            ENG_ADDR:   ev_code = rd_dir ? (got_ack ? ST_AR_ACK : ST_AR_NAK)
                                         : (got_ack ? ST_AW_ACK : ST_AW_NAK);
            ENG_WRITE:  ev_code = got_ack ? ST_DW_ACK : ST_DW_NAK;
            ENG_READ:   ev_code = ack_q ? ST_DR_ACK : ST_DR_NAK;
            default:    ev_code = ST_IDLE;
        endcase
    end

    // state register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || clr) begin
            state <= ENG_IDLE; ph <= '0; bitn <= '0; shreg <= '0;
            rd_dir <= 1'b0; got_ack <= 1'b0; ack_q <= 1'b0; after_start <= 1'b0;
        end else begin
            unique case (state)
                ENG_IDLE: begin
                    if (en && start_req && !flag) begin
                        state <= ENG_START;
                        ph    <= '0;
                    end
                end
                ENG_HOLD: begin
                    if (!flag) begin
                        ph   <= '0;
                        bitn <= '0;
                        if (stop_req)         state <= ENG_STOP;
                        else if (start_req)   state <= ENG_RSTART;
                        else if (after_start) begin
                            state  <= ENG_ADDR;
                            shreg  <= tx_byte;
                            rd_dir <= tx_byte[0];
                        end else if (rd_dir) begin
                            state <= ENG_READ;
                            ack_q <= ack_en;
                        end else begin
                            state <= ENG_WRITE;
                            shreg <= tx_byte;
                        end
                    end
                end
                default: begin
                    if (tick) begin
                        if (ph == PH_SAMPLE && is_byte) begin
                            if (state == ENG_READ && bitn != BIT_ACK)
                                shreg <= {shreg[BYTE_W-2:0], sda_in};
                            if (state != ENG_READ && bitn == BIT_ACK)
                                got_ack <= !sda_in;
                        end
                        if (ph == last_ph) begin
                            ph <= '0;
                            if (is_byte && bitn != BIT_ACK) begin
                                bitn <= bitn + 4'd1;
                                if (state != ENG_READ) shreg <= {shreg[BYTE_W-2:0], 1'b0};
                            end else begin
                                state       <= (state == ENG_STOP) ? ENG_IDLE : ENG_HOLD;
                                after_start <= (state == ENG_START) || (state == ENG_RSTART);
                            end
                        end else begin
                            ph <= ph + 4'd1;
                        end
                    end
                end
            endcase
        end
    end

    // line drive
    always_comb begin
        scl_pull = 1'b0;
        sda_pull = 1'b0;
        unique case (state)
            ENG_IDLE: ;
            ENG_HOLD: begin
                scl_pull = 1'b1;
                sda_pull = after_start;
            end
            ENG_START: sda_pull = 1'b1;
            ENG_RSTART: begin
                scl_pull = (ph < 4'd5);
                sda_pull = (ph >= 4'd10);
            end
            ENG_STOP: begin
                scl_pull = (ph < 4'd5);
                sda_pull = (ph < 4'd10);
            end
            default: begin
                scl_pull = (ph < 4'd3) || (ph > 4'd7);
                if (bitn == BIT_ACK) sda_pull = (state == ENG_READ) && ack_q;
                else                 sda_pull = (state != ENG_READ) && !shreg[BYTE_W-1];
            end
        endcase
    end
endmodule

// File: rtl/i2cm_ctrl.sv
module i2cm_ctrl
    import i2cm_pkg::*;
#(
    parameter int ADDR_W = 5,
    parameter int M_W    = 4,
    parameter int N_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    output logic              irq,
    output logic              scl_pull,
    output logic              sda_pull,
    input  logic              sda_in
);
    localparam int RATE_W = M_W + N_W;

    logic              ack_en, flag, stop_req, start_req, en, ien;
    logic [BYTE_W-1:0] data_q, status_q, rx_byte;
    logic [RATE_W-1:0] rate_q;
    logic [7:0]        ev_code;
    logic              ev_done, run, tick, soft_wr;
    eng_state_t        eng_state;

    assign soft_wr = reg_wr && (reg_addr == ADDR_W'(OFS_SRST));
    assign irq     = flag && ien;

    i2cm_tick #(.M_W(M_W), .N_W(N_W)) u_tick (
        .clk(clk), .rst_n(rst_n), .run(run),
        .m_fld(rate_q[RATE_W-1:N_W]), .n_fld(rate_q[N_W-1:0]), .tick(tick)
    );

    i2cm_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .clr(soft_wr), .tick(tick), .en(en),
        .start_req(start_req), .stop_req(stop_req), .ack_en(ack_en), .flag(flag),
        .tx_byte(data_q), .sda_in(sda_in), .state_o(eng_state), .run(run),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .ev_done(ev_done),
        .ev_code(ev_code), .rx_byte(rx_byte)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n || soft_wr) begin
            ack_en <= 1'b0; flag <= 1'b0; stop_req <= 1'b0; start_req <= 1'b0;
            en <= 1'b0; ien <= 1'b0; data_q <= '0; status_q <= ST_IDLE; rate_q <= '0;
        end else begin
            if (ev_done) begin
                status_q <= ev_code;
                if (ev_code == ST_IDLE) stop_req <= 1'b0;
                else                    flag     <= 1'b1;
                if (ev_code == ST_START || ev_code == ST_RSTART) start_req <= 1'b0;
                if (eng_state == ENG_READ) data_q <= rx_byte;
            end
            if (reg_wr) begin
                if (reg_addr == ADDR_W'(OFS_CTRL)) begin
                    ack_en    <= reg_wdata[CB_ACK];
                    stop_req  <= reg_wdata[CB_STOP];
                    start_req <= reg_wdata[CB_START];
                    en        <= reg_wdata[CB_EN];
                    ien       <= reg_wdata[CB_IEN];
                    if (!reg_wdata[CB_FLAG]) flag <= 1'b0;
                end
                if (reg_addr == ADDR_W'(OFS_DATA)) data_q <= reg_wdata;
                if (reg_addr == ADDR_W'(OFS_STAT)) rate_q <= reg_wdata[RATE_W-1:0];
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == ADDR_W'(OFS_DATA)) reg_rdata = data_q;
        if (reg_addr == ADDR_W'(OFS_CTRL))
            reg_rdata = {ien, en, start_req, stop_req, flag, ack_en, 2'b00};
        if (reg_addr == ADDR_W'(OFS_STAT)) reg_rdata = status_q;
    end
endmodule

// File: rtl/i2cm_ctrl_chk.sv
module i2cm_ctrl_chk
    import i2cm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       soft_wr,
    input logic       flag,
    input logic       stop_req,
    input logic       irq,
    input eng_state_t state,
    input logic       scl_pull,
    input logic       sda_pull,
    input logic [7:0] status
);
    AST_HOLD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> scl_pull); // R3

    AST_FLAG_ONLY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        flag |-> (state == ENG_HOLD)); // R3

    AST_IDLE_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ENG_IDLE) |-> (status == ST_IDLE && !irq)); // R8

    AST_STOP_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ENG_STOP && state == ENG_IDLE) |-> (!stop_req && !flag)); // R8

    AST_SRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(soft_wr) |-> (state == ENG_IDLE && status == ST_IDLE)); // R10

    AST_SDA_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (!scl_pull && $past(!scl_pull) && $past(state) == state &&
         (state == ENG_ADDR || state == ENG_WRITE || state == ENG_READ))
        |-> $stable(sda_pull)); // R4
endmodule

bind i2cm_ctrl i2cm_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .soft_wr(soft_wr), .flag(flag), .stop_req(stop_req),
    .irq(irq), .state(eng_state), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .status(status_q)
);

// File: tb/i2cm_ctrl_tb.sv
module i2cm_ctrl_tb;
    localparam int CLK_PERIOD = 10;
    localparam logic [6:0] SLV = 7'h52;

    logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
    logic [4:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0, reg_rdata;
    logic irq, scl_pull, sda_pull, sda_in;
    logic slv_pull = 1'b0;
    logic scl_line, sda_line;

    int n_checks = 0, n_errs = 0;
    int starts = 0, stops = 0, last_hi = 0, hi_cnt = 0;
    logic frozen = 1'b0;
    logic [7:0] last_addr = '0, last_wr = '0;
    logic mack = 1'b0, ack_writes = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign scl_line = !scl_pull;
    assign sda_line = !(sda_pull || slv_pull);
    assign sda_in   = sda_line;

    i2cm_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_pull(scl_pull), .sda_pull(sda_pull), .sda_in(sda_in)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [7:0] d);
        @(negedge clk); reg_addr = a; #1 d = reg_rdata;
    endtask

    task automatic wait_flag(input string req);
        logic [7:0] c;
        int n;
        n = 0;
        c = 8'h00;
        while (!c[3] && n < 20000) begin rd(5'h08, c); n++; end
        if (!c[3]) chk(1'b0, req, 0, 1);
    endtask

    task automatic expect_reg(input logic [4:0] a, input logic [7:0] exp, input string req);
        logic [7:0] v;
        rd(a, v);
        chk(v === exp, req, v, exp);
    endtask

    // behavioural bus slave and per-clock checks
    logic prev_scl = 1'b1, prev_sda = 1'b1, in_frame = 1'b0, is_addr = 1'b0;
    logic reading = 1'b0, addr_ok = 1'b0;
    logic [7:0] sh = '0, cur_tx = '0;
    logic [7:0] rd_bytes [2] = '{8'h3C, 8'hC1};
    int bcnt = 0, rd_idx = 0;

    always @(negedge clk) begin
        if (frozen) chk(scl_pull === 1'b1, "R3 scl held low while flag set", scl_pull, 1);
        if (scl_line) hi_cnt++;
        if (!rst_n) begin
            slv_pull = 1'b0; in_frame = 1'b0;
        end else if (scl_line && prev_scl && prev_sda && !sda_line) begin
            starts++; in_frame = 1'b1; bcnt = 0; is_addr = 1'b1; slv_pull = 1'b0;
        end else if (scl_line && prev_scl && !prev_sda && sda_line) begin
            stops++; in_frame = 1'b0; slv_pull = 1'b0;
        end else if (in_frame && scl_line && !prev_scl) begin
            if (bcnt < 8) begin
                if (!(reading && !is_addr)) sh = {sh[6:0], sda_line};
                bcnt++;
            end else begin
                mack = !sda_line; bcnt = 9;
            end
        end else if (in_frame && !scl_line && prev_scl) begin
            if (bcnt == 8) begin
                if (is_addr) begin
                    last_addr = sh; addr_ok = (sh[7:1] == SLV);
                    reading = sh[0] && addr_ok; rd_idx = 0; slv_pull = addr_ok;
                end else if (!reading) begin
                    last_wr = sh; slv_pull = ack_writes;
                end else slv_pull = 1'b0;
            end else if (bcnt == 9) begin
                bcnt = 0;
                if (reading && (is_addr || mack)) begin
                    if (!is_addr) rd_idx++;
                    cur_tx = rd_bytes[rd_idx % 2];
                    slv_pull = !cur_tx[7];
                end else begin
                    slv_pull = 1'b0; reading = 1'b0;
                end
                is_addr = 1'b0;
            end else if (reading && !is_addr) slv_pull = !cur_tx[7-bcnt];
        end
        if (!scl_line && prev_scl) begin last_hi = hi_cnt; hi_cnt = 0; end
        if (!scl_line) hi_cnt = 0;
        prev_scl = scl_line; prev_sda = sda_line;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        chk(1'b0, "watchdog expired", 0, 1);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        expect_reg(5'h0C, 8'hF8, "R1 status after reset");
        expect_reg(5'h08, 8'h00, "R1 control after reset");
        chk(!irq && !scl_pull && !sda_pull, "R1 lines and irq idle", {irq, scl_pull, sda_pull}, 0);

        // R2 start without enable has no effect
        wr(5'h08, 8'h20);
        repeat (200) @(negedge clk);
        chk(starts == 0 && !scl_pull, "R2 no START without enable", starts, 0);
        expect_reg(5'h0C, 8'hF8, "R2 status unchanged without enable");
        wr(5'h08, 8'h00);

        // R9 rate M=1 N=0, R2 START
        wr(5'h0C, 8'h08);
        wr(5'h08, 8'hE4);
        wait_flag("R2 flag after START");
        expect_reg(5'h0C, 8'h08, "R2 START status");
        expect_reg(5'h08, 8'hCC, "R2 start bit self-cleared");
        chk(starts == 1, "R2 START seen on bus", starts, 1);
        chk(irq === 1'b1, "R11 irq with flag and enable", irq, 1);
        frozen = 1'b1; repeat (50) @(negedge clk); frozen = 1'b0;

        // R3 writing one to flag keeps it; R4 address write
        wr(5'h04, {SLV, 1'b0});
        wr(5'h08, 8'hCC);
        frozen = 1'b1; repeat (100) @(negedge clk); frozen = 1'b0;
        expect_reg(5'h0C, 8'h08, "R3 no event while flag set");
        wr(5'h08, 8'hC4);
        wait_flag("R4 flag after address");
        expect_reg(5'h0C, 8'h18, "R4 write address acked");
        chk(last_addr == {SLV, 1'b0}, "R4 address byte on bus", last_addr, {SLV, 1'b0});
        chk(last_hi == 10, "R9 SCL high time M=1 N=0", last_hi, 10);

        // R11 irq off with ien clear; R5 data write
        wr(5'h08, 8'h4C);
        chk(irq === 1'b0, "R11 irq low with ien clear", irq, 0);
        wr(5'h04, 8'hA5);
        wr(5'h08, 8'h44);
        wait_flag("R5 flag after data");
        expect_reg(5'h0C, 8'h28, "R5 data acked");
        chk(last_wr == 8'hA5, "R5 data byte on bus", last_wr, 8'hA5);
        ack_writes = 1'b0;
        wr(5'h04, 8'h5A);
        wr(5'h08, 8'h44);
        wait_flag("R5 flag after nacked data");
        expect_reg(5'h0C, 8'h30, "R5 data not acked");
        ack_writes = 1'b1;

        // R7 repeated start
        wr(5'h08, 8'h6C);
        repeat (100) @(negedge clk);
        chk(starts == 1, "R7 no repeated START before flag clear", starts, 1);
        wr(5'h08, 8'h64);
        wait_flag("R7 flag after repeated START");
        expect_reg(5'h0C, 8'h10, "R7 repeated START status");
        chk(starts == 2, "R7 repeated START on bus", starts, 2);

        // R4 read address, R6 reads
        wr(5'h04, {SLV, 1'b1});
        wr(5'h08, 8'h44);
        wait_flag("R4 flag after read address");
        expect_reg(5'h0C, 8'h40, "R4 read address acked");
        wr(5'h08, 8'h44);
        wait_flag("R6 flag after acked read");
        expect_reg(5'h0C, 8'h50, "R6 read with ack status");
        expect_reg(5'h04, 8'h3C, "R6 first received byte");
        chk(mack === 1'b1, "R6 master drove ack", mack, 1);
        wr(5'h08, 8'h40);
        wait_flag("R6 flag after last read");
        expect_reg(5'h0C, 8'h58, "R6 read without ack status");
        expect_reg(5'h04, 8'hC1, "R6 second received byte");
        chk(mack === 1'b0, "R6 master left ack off", mack, 0);

        // R8 stop
        wr(5'h08, 8'h50);
        begin
            logic [7:0] c;
            int n;
            c = 8'h10; n = 0;
            while (c[4] && n < 20000) begin rd(5'h08, c); n++; end
        end
        expect_reg(5'h08, 8'h40, "R8 stop bit self-cleared, flag clear");
        expect_reg(5'h0C, 8'hF8, "R8 idle status after STOP");
        chk(stops == 1, "R8 STOP on bus", stops, 1);
        chk(!scl_pull && !sda_pull, "R8 lines released", {scl_pull, sda_pull}, 0);

        // R9 rate M=2 N=1, R4 address nack
        wr(5'h0C, 8'h11);
        wr(5'h08, 8'h64);
        wait_flag("R2 flag after second START");
        wr(5'h04, 8'h22);
        wr(5'h08, 8'h44);
        wait_flag("R4 flag after wrong address");
        expect_reg(5'h0C, 8'h20, "R4 write address not acked");
        chk(last_hi == 30, "R9 SCL high time M=2 N=1", last_hi, 30);

        // R10 soft reset
        wr(5'h1C, 8'h00);
        expect_reg(5'h0C, 8'hF8, "R10 status after soft reset");
        expect_reg(5'h08, 8'h00, "R10 control after soft reset");
        chk(!scl_pull && !sda_pull && !irq, "R10 lines and irq after soft reset",
            {irq, scl_pull, sda_pull}, 0);

        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule